// File: doc/BRIEF.md
# Directory Coherence Controller

This block is the central point that keeps processor caches coherent for a set of memory lines. It sits beside the memory controller and keeps one directory entry per tracked line. Each entry holds a presence vector with one bit per processor and an exclusive flag. Processors send a read-miss request or a write-exclusive request. The controller looks up the line, works out which caches must act, and sends them targeted commands. It sends an invalidate to every other holder before a write, and a write-back to an exclusive owner before someone else reads. It waits for every targeted cache to acknowledge, then updates the entry and returns a grant to the requester.

Only one transaction is in service at a time. A second request waits with `req_ready` low until the current transaction ends, so requests to the same line are serialised. Caches, the interconnect and data movement are outside the block; they appear only as request, command, acknowledge and grant ports.

Top module: `dir_coherence_ctrl`

## Requirements
- R1: After reset every line is uncached. `req_ready` is high, and `cmd_valid` and `grant_valid` are low. The first request to any line is granted with no commands.
- R2: A request is taken when `req_valid` and `req_ready` are both high. `req_write`=0 means a read miss and `req_write`=1 means a write-exclusive request. While a transaction waits for acknowledgements, `req_ready` stays low, and a pending request is held until the grant of the current one.
- R3: A read miss to a line that no other processor holds exclusively is granted in the cycle after acceptance, with no commands. The requester becomes a sharer and the line is not exclusive.
- R4: A read miss to a line held exclusively by another processor sends a write-back (`cmd_wb`=1) only to that owner, in the cycle after acceptance, with `cmd_line` set to the line. After the grant, the former owner and the requester are both sharers and the line is no longer exclusive.
- R5: A write-exclusive request sends an invalidate (`cmd_wb`=0) to every holder of the line except the requester, in the cycle after acceptance. After the grant, only the requester holds the line, and it holds it exclusively.
- R6: When commands were sent, the grant appears in the cycle after the last outstanding acknowledgement is sampled and never earlier. Acknowledgements may arrive one at a time, in any order, or several in one cycle.
- R7: An acknowledgement from a processor that is not still outstanding in the current transaction is ignored and does not bring the grant forward.
- R8: A read or write request from the processor that already holds the line exclusively is granted in the cycle after acceptance, with no commands and no change to the entry.
- R9: A grant carries the requester in `grant_proc`, the line in `grant_line`, and the request type in `grant_write`. It lasts exactly one cycle.
- R10: A write-exclusive request from a processor that is the only sharer of the line is granted in the cycle after acceptance, with no commands. That processor then holds the line exclusively.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller can take a request |
| req_proc | input | 2 | Requesting processor |
| req_line | input | 4 | Requested line |
| req_write | input | 1 | 0 read miss, 1 write-exclusive |
| ack_valid | input | 4 | One acknowledge bit per processor |
| cmd_valid | output | 4 | Command target per processor, one-cycle pulse |
| cmd_wb | output | 1 | 1 write-back, 0 invalidate |
| cmd_line | output | 4 | Line the command refers to |
| grant_valid | output | 1 | Grant pulse |
| grant_proc | output | 2 | Processor being granted |
| grant_line | output | 4 | Line being granted |
| grant_write | output | 1 | Grant is for write-exclusive |

## Verification
The hardest situation to reach is a second request that arrives while the controller is waiting for acknowledgements, combined with staggered acknowledgements and stray ones from processors that are not outstanding. The bench reaches it in two ways. A directed case builds three sharers and then asserts another request throughout the invalidate phase. A long pseudo-random phase then releases acknowledgements in random subsets, mixed with spurious bits. Across that phase, a shadow directory in the bench predicts every command vector, every grant cycle, and the entry state that each later request reveals.

// File: rtl/dir_coh_pkg.sv
package dir_coh_pkg;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_WAIT = 1'b1
    } dir_state_e;

    localparam logic KIND_READ  = 1'b0;
    localparam logic KIND_WRITE = 1'b1;

    localparam logic CMD_INV = 1'b0;
    localparam logic CMD_WB  = 1'b1;

endpackage

// File: rtl/dir_table.sv
module dir_table #(
    parameter int NPROC  = 4,
    parameter int NLINES = 16,
    parameter int LW     = (NLINES > 1) ? $clog2(NLINES) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LW-1:0]    rd_line,
    output logic [NPROC-1:0] rd_pres,
    output logic             rd_excl,
    input  logic             wr_en,
    input  logic [LW-1:0]    wr_line,
    input  logic [NPROC-1:0] wr_pres,
    input  logic             wr_excl
);

    logic [NPROC-1:0]  pres_q [NLINES];
    logic [NPROC-1:0]  pres_d [NLINES];
    logic [NLINES-1:0] excl_q;
    logic [NLINES-1:0] excl_d;

    always_comb begin
        pres_d = pres_q;
        excl_d = excl_q;
        if (wr_en) begin
            pres_d[wr_line] = wr_pres;
            excl_d[wr_line] = wr_excl;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NLINES; i++) begin
                pres_q[i] <= '0;
            end
            excl_q <= '0;
        end else begin
            pres_q <= pres_d;
            excl_q <= excl_d;
        end
    end

    assign rd_pres = pres_q[rd_line];
    assign rd_excl = excl_q[rd_line];

    // An exclusive entry always names exactly one holder (R4, R5)
    p_excl_single_owner_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_excl) |-> $onehot(wr_pres));

    p_read_excl_onehot_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rd_excl |-> $onehot(rd_pres));

endmodule

// File: rtl/dir_plan.sv
module dir_plan #(
    parameter int NPROC = 4,
    parameter int PW    = (NPROC > 1) ? $clog2(NPROC) : 1
) (
    input  logic             is_write,
    input  logic [PW-1:0]    src,
    input  logic [NPROC-1:0] pres,
    input  logic             excl,
    output logic [NPROC-1:0] targets,
    output logic             use_wb,
    output logic [NPROC-1:0] new_pres,
    output logic             new_excl
);
    import dir_coh_pkg::*;

    logic [NPROC-1:0] self_bit;
    logic             owned_by_self;

    assign self_bit      = NPROC'(1) << src;
    assign owned_by_self = excl && (pres == self_bit);

    always_comb begin
        targets  = '0;
        use_wb   = CMD_INV;
        new_pres = pres;
        new_excl = excl;
        if (owned_by_self) begin
            // exclusive holder asking again: nothing to do
        end else if (is_write == KIND_READ) begin
            if (excl) begin
                targets = pres;
                use_wb  = CMD_WB;
            end
            new_pres = pres | self_bit;
            new_excl = 1'b0;
        end else begin
            targets  = pres & ~self_bit;
            new_pres = self_bit;
            new_excl = 1'b1;
        end
    end

endmodule

// File: rtl/dir_coherence_ctrl.sv
module dir_coherence_ctrl #(
    parameter int NPROC  = 4,
    parameter int NLINES = 16,
    parameter int PW     = (NPROC > 1) ? $clog2(NPROC) : 1,
    parameter int LW     = (NLINES > 1) ? $clog2(NLINES) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [PW-1:0]    req_proc,
    input  logic [LW-1:0]    req_line,
    input  logic             req_write,
    input  logic [NPROC-1:0] ack_valid,
    output logic [NPROC-1:0] cmd_valid,
    output logic             cmd_wb,
    output logic [LW-1:0]    cmd_line,
    output logic             grant_valid,
    output logic [PW-1:0]    grant_proc,
    output logic [LW-1:0]    grant_line,
    output logic             grant_write
);
    import dir_coh_pkg::*;

    localparam int CW = $clog2(NPROC + 1);

    typedef struct packed {
        dir_state_e       state;
        logic [PW-1:0]    proc;
        logic [LW-1:0]    line;
        logic             write;
        logic [NPROC-1:0] new_pres;
        logic             new_excl;
        logic [NPROC-1:0] mask;
        logic [CW-1:0]    cnt;
        logic [NPROC-1:0] cmd_valid;
        logic             cmd_wb;
        logic             grant_valid;
    } ctl_t;

    ctl_t s_q, s_d;

    logic [NPROC-1:0] rd_pres;
    logic             rd_excl;
    logic             tbl_wr_en;
    logic [LW-1:0]    tbl_wr_line;
    logic [NPROC-1:0] tbl_wr_pres;
    logic             tbl_wr_excl;
    logic [NPROC-1:0] plan_targets;
    logic             plan_wb;
    logic [NPROC-1:0] plan_pres;
    logic             plan_excl;
    logic [NPROC-1:0] hits;

    dir_table #(.NPROC(NPROC), .NLINES(NLINES), .LW(LW)) u_table (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_line (req_line),
        .rd_pres (rd_pres),
        .rd_excl (rd_excl),
        .wr_en   (tbl_wr_en),
        .wr_line (tbl_wr_line),
        .wr_pres (tbl_wr_pres),
        .wr_excl (tbl_wr_excl)
    );

    dir_plan #(.NPROC(NPROC), .PW(PW)) u_plan (
        .is_write (req_write),
        .src      (req_proc),
        .pres     (rd_pres),
        .excl     (rd_excl),
        .targets  (plan_targets),
        .use_wb   (plan_wb),
        .new_pres (plan_pres),
        .new_excl (plan_excl)
    );

    assign hits = ack_valid & s_q.mask;

    always_comb begin
        s_d             = s_q;
        s_d.cmd_valid   = '0;
        s_d.grant_valid = 1'b0;
        tbl_wr_en       = 1'b0;
        tbl_wr_line     = s_q.line;
        tbl_wr_pres     = s_q.new_pres;
        tbl_wr_excl     = s_q.new_excl;
        case (s_q.state)
            ST_IDLE: begin
                if (req_valid) begin
                    s_d.proc  = req_proc;
                    s_d.line  = req_line;
                    s_d.write = req_write;
                    if (plan_targets == '0) begin
                        tbl_wr_en       = 1'b1;
                        tbl_wr_line     = req_line;
                        tbl_wr_pres     = plan_pres;
                        tbl_wr_excl     = plan_excl;
                        s_d.grant_valid = 1'b1;
                    end else begin
                        s_d.state     = ST_WAIT;
                        s_d.mask      = plan_targets;
                        s_d.cnt       = CW'($countones(plan_targets));
                        s_d.cmd_valid = plan_targets;
                        s_d.cmd_wb    = plan_wb;
                        s_d.new_pres  = plan_pres;
                        s_d.new_excl  = plan_excl;
                    end
                end
            end
            ST_WAIT: begin
                s_d.mask = s_q.mask & ~hits;
                s_d.cnt  = s_q.cnt - CW'($countones(hits));
                if (s_d.cnt == '0) begin
                    tbl_wr_en       = 1'b1;
                    s_d.grant_valid = 1'b1;
                    s_d.state       = ST_IDLE;
                end
            end
            default: s_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign req_ready   = (s_q.state == ST_IDLE);
    assign cmd_valid   = s_q.cmd_valid;
    assign cmd_wb      = s_q.cmd_wb;
    assign cmd_line    = s_q.line;
    assign grant_valid = s_q.grant_valid;
    assign grant_proc  = s_q.proc;
    assign grant_line  = s_q.line;
    assign grant_write = s_q.write;

    // Write-back goes to a single owner only (R4)
    p_wb_single_owner_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ((cmd_valid != '0) && cmd_wb) |-> $onehot(cmd_valid));

    // Requester is never a command target (R5)
    p_no_self_command_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid != '0) |-> !cmd_valid[grant_proc]);

    // No grant while acknowledgements remain (R6)
    p_no_early_grant_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.cnt != '0) |-> !grant_valid);

    // Commands mean a transaction is open, so no new request is taken (R2)
    p_busy_not_ready_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid != '0) |-> !req_ready);

    // A grant is a single-cycle pulse (R9)
    p_grant_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_valid && !req_valid) |=> !grant_valid);

endmodule

// File: tb/dir_coherence_ctrl_bench.sv
module dir_coherence_ctrl_bench;

    localparam int CLK_PERIOD = 10;
    localparam int NP = 4;
    localparam int NL = 16;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       req_valid;
    logic       req_ready;
    logic [1:0] req_proc;
    logic [3:0] req_line;
    logic       req_write;
    logic [3:0] ack_valid;
    logic [3:0] cmd_valid;
    logic       cmd_wb;
    logic [3:0] cmd_line;
    logic       grant_valid;
    logic [1:0] grant_proc;
    logic [3:0] grant_line;
    logic       grant_write;

    int checks = 0;
    int errors = 0;
    int cyc    = 0;

    logic [3:0]  m_pres [NL];
    logic        m_ex   [NL];
    logic [15:0] lfsr = 16'hACE1;

    // request held in the background during a busy transaction
    int hp, hl;
    bit hw;

    dir_coherence_ctrl u_dir_coherence_ctrl (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_proc(req_proc), .req_line(req_line), .req_write(req_write),
        .ack_valid(ack_valid), .cmd_valid(cmd_valid), .cmd_wb(cmd_wb),
        .cmd_line(cmd_line), .grant_valid(grant_valid), .grant_proc(grant_proc),
        .grant_line(grant_line), .grant_write(grant_write)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            errors = errors + 1;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic step_lfsr();
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    endtask

    // Caller stands at a negedge; returns at a negedge.
    task automatic run_req(input int p, input int l, input bit w, input bit hold);
        logic [3:0] self_b, pres, tgt, np, rem, pick, stray;
        logic       ex, wb, ne;
        string      tag;
        int         n;
        self_b = 4'(1) << p;
        pres = m_pres[l];
        ex = m_ex[l];
        tgt = '0; wb = 1'b0; np = pres; ne = ex;
        if (ex && pres == self_b) begin
            tag = "R8";
        end else if (!w) begin
            if (ex) begin tgt = pres; wb = 1'b1; end
            np = pres | self_b; ne = 1'b0;
            tag = (pres == '0) ? "R1" : "R3";
        end else begin
            tgt = pres & ~self_b; np = self_b; ne = 1'b1;
            tag = (pres == '0) ? "R1" : "R10";
        end
        req_valid = 1'b1; req_proc = 2'(p); req_line = 4'(l); req_write = w;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        if (tgt == '0) begin
            chk({tag, " immediate grant"}, int'(grant_valid), 1);
            chk({tag, " no command"}, int'(cmd_valid), 0);
            chk("R9 grant_proc", int'(grant_proc), p);
            chk("R9 grant_line", int'(grant_line), l);
            chk("R9 grant_write", int'(grant_write), int'(w));
        end else begin
            chk(wb ? "R4 write-back targets" : "R5 invalidate targets", int'(cmd_valid), int'(tgt));
            chk(wb ? "R4 command kind" : "R5 command kind", int'(cmd_wb), int'(wb));
            chk("R4 R5 cmd_line", int'(cmd_line), l);
            chk("R6 no grant before acks", int'(grant_valid), 0);
            chk("R2 ready low while busy", int'(req_ready), 0);
            rem = tgt;
            n = 0;
            while (rem != '0) begin
                step_lfsr();
                pick = lfsr[3:0] & rem;
                if (n >= 3) pick = rem;
                stray = lfsr[7:4] & ~rem;
                ack_valid = pick | stray;
                rem = rem & ~pick;
                if (hold) begin
                    req_valid = 1'b1; req_proc = 2'(hp); req_line = 4'(hl); req_write = hw;
                end
                @(posedge clk);
                @(negedge clk);
                ack_valid = '0;
                n++;
                if (rem != '0) begin
                    chk("R6 R7 no grant while acks outstanding", int'(grant_valid), 0);
                    chk("R6 no repeated command", int'(cmd_valid), 0);
                    if (hold) chk("R2 held request not taken", int'(req_ready), 0);
                end
            end
            chk("R6 grant after last ack", int'(grant_valid), 1);
            chk("R9 grant_proc", int'(grant_proc), p);
            chk("R9 grant_line", int'(grant_line), l);
            chk("R9 grant_write", int'(grant_write), int'(w));
            chk("R2 ready back after grant", int'(req_ready), 1);
        end
        m_pres[l] = np;
        m_ex[l] = ne;
    endtask

    initial begin
        rst_n = 1'b0;
        req_valid = 1'b0; req_proc = '0; req_line = '0; req_write = 1'b0;
        ack_valid = '0;
        for (int i = 0; i < NL; i++) begin
            m_pres[i] = '0;
            m_ex[i] = 1'b0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 ready after reset", int'(req_ready), 1);
        chk("R1 no command after reset", int'(cmd_valid), 0);
        chk("R1 no grant after reset", int'(grant_valid), 0);

        // R1 R3: first touch of every line
        for (int l = 0; l < NL; l++) run_req(l % NP, l, 1'b0, 1'b0);

        // R10, R8, R4, R5 on line 0
        run_req(0, 0, 1'b1, 1'b0);
        run_req(0, 0, 1'b1, 1'b0);
        run_req(0, 0, 1'b0, 1'b0);
        run_req(2, 0, 1'b0, 1'b0);
        run_req(3, 0, 1'b1, 1'b0);

        // R2: a request is held during a three-way invalidate
        run_req(0, 5, 1'b0, 1'b0);
        run_req(2, 5, 1'b0, 1'b0);
        run_req(3, 5, 1'b0, 1'b0);
        hp = 0; hl = 7; hw = 1'b1;
        run_req(1, 5, 1'b1, 1'b1);
        run_req(0, 7, 1'b1, 1'b0);

        // Long pseudo-random sweep
        for (int k = 0; k < 1500; k++) begin
            step_lfsr();
            run_req(int'(lfsr[1:0]), int'(lfsr[5:2]), lfsr[8], 1'b0);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule